// File: doc/BRIEF.md
# Thermal Threshold Interrupt Unit

This unit watches a stream of 12-bit temperature codes and raises an interrupt when the code moves across one of three programmable trip levels. A code arrives with a one-cycle valid strobe. The unit compares each new code with the code that came before it, so it detects crossings and not levels. Every trip level has two event bits. One bit records a move from below the level to at or above it. The other bit records a move from at or above the level to below it.

Software uses a 32-bit register bus with separate read and write strobes. Through it, software programs the trip levels and sets three per-event masks:

- an event-type select,
- an arm (enable),
- an interrupt mask.

Software also reads and clears the pending events and reads back the latest code. A usual setup arms the falling event of level 1 as a low trip and the rising event of level 2 as a high trip. The single interrupt line is the OR of the pending events that are unmasked.

Top module: `thermal_trip_irq`

## Requirements
- R1: After synchronous reset, every register reads zero and `irq_out` is low.
- R2: Registers sit at these byte addresses: pending 0x04, interrupt mask 0x08, event select 0x0C, arm 0x10, trip levels 1, 2 and 3 at 0x14, 0x18 and 0x1C. Reads return data in the cycle after the `bus_rd` edge. The 6-bit registers keep only bits 5:0 and the trip levels keep only bits 11:0. Upper bits always read zero.
- R3: Address 0x28 returns the most recent valid code in bits 11:0, with zeros above. Writes to it are ignored.
- R4: Pending, mask, select and arm all share one layout: bits 0, 1 and 2 are the rising events of levels 1, 2 and 3, and bits 3, 4 and 5 are the falling events of levels 1, 2 and 3. A rising event means the previous code < level and the new code >= level. A falling event means the previous code >= level and the new code < level. The pending bit sets at the clock edge that samples the crossing code.
- R5: The first valid code after reset never raises an event. A repeated code never raises an event.
- R6: A pending bit sets only when both its arm bit and its select bit are 1.
- R7: A write to the pending register clears each bit written as 0 and keeps each bit written as 1. Writing 0 clears all of them.
- R8: If an event sets a bit in the same cycle that a write clears it, the bit ends set.
- R9: `irq_out` is the OR over all bits of (pending AND mask). Pending bits keep recording while masked. `irq_out` responds in the cycle after a mask or pending write.
- R10: Addresses outside the map read as zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| code_in | input | 12 | Temperature code |
| code_valid | input | 1 | Code strobe, one sample per high cycle |
| irq_out | output | 1 | Combined interrupt |

## Verification
The assertions assume that `code_valid` and `code_in` are stable around each clock edge and that bus strobes carry a settled address. The crossing checks also assume that the trip levels do not change in the same cycle as a code sample. The bench meets these assumptions by driving every input only on the falling clock edge. It programs the trip levels and selects before it sends codes, and it sends at most one code or one bus access per cycle. The one exception is the deliberate same-cycle set-and-clear case.

// File: rtl/thr_pkg.sv
package thr_pkg;
    localparam int CODE_W = 12;
    localparam int NUM_LVL = 3;
    localparam int EVT_W = 2 * NUM_LVL;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;

    localparam logic [7:0] OFS_PEND = 8'h04;
    localparam logic [7:0] OFS_MASK = 8'h08;
    localparam logic [7:0] OFS_SEL  = 8'h0C;
    localparam logic [7:0] OFS_ARM  = 8'h10;
    localparam logic [7:0] OFS_LVL0 = 8'h14;
    localparam logic [7:0] OFS_CODE = 8'h28;

    typedef enum logic [2:0] {
        RS_NONE, RS_PEND, RS_MASK, RS_SEL, RS_ARM, RS_LVL, RS_CODE
    } rsel_e;

    function automatic logic [7:0] lvl_addr(input int idx);
        return OFS_LVL0 + 8'(4 * idx);
    endfunction
endpackage

// File: rtl/thr_regs.sv
module thr_regs #(
    parameter int CW = thr_pkg::CODE_W,
    parameter int NL = thr_pkg::NUM_LVL,
    parameter int AW = thr_pkg::ADDR_W,
    parameter int DW = thr_pkg::DATA_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [AW-1:0]        bus_addr,
    input  logic                 bus_wr,
    input  logic [DW-1:0]        bus_wdata,
    input  logic                 bus_rd,
    output logic [DW-1:0]        bus_rdata,
    input  logic [2*NL-1:0]      pend_i,
    input  logic [CW-1:0]        code_i,
    output logic [NL-1:0][CW-1:0] lvl_o,
    output logic [2*NL-1:0]      mask_o,
    output logic [2*NL-1:0]      sel_o,
    output logic [2*NL-1:0]      arm_o,
    output logic                 pend_wr_o,
    output logic [2*NL-1:0]      pend_wdata_o
);
    import thr_pkg::*;
    localparam int EW = 2 * NL;

    logic [NL-1:0] lvl_hit;
    logic [NL-1:0][CW-1:0] lvl_q;
    logic [EW-1:0] mask_q, sel_q, arm_q;
    rsel_e rsel;
    logic [DW-1:0] rd_mux;
    logic any_hit;
    logic unused_upper;

    assign unused_upper = ^bus_wdata[DW-1:CW];

    for (genvar i = 0; i < NL; i++) begin : g_lvl
        assign lvl_hit[i] = (bus_addr == AW'(lvl_addr(i)));
        always_ff @(posedge clk) begin
            if (rst)
                lvl_q[i] <= '0;
            else if (bus_wr && lvl_hit[i])
                lvl_q[i] <= bus_wdata[CW-1:0];
        end
    end

    always_comb begin
        rsel = RS_NONE;
        if (bus_addr == AW'(OFS_PEND))      rsel = RS_PEND;
        else if (bus_addr == AW'(OFS_MASK)) rsel = RS_MASK;
        else if (bus_addr == AW'(OFS_SEL))  rsel = RS_SEL;
        else if (bus_addr == AW'(OFS_ARM))  rsel = RS_ARM;
        else if (bus_addr == AW'(OFS_CODE)) rsel = RS_CODE;
        else if (|lvl_hit)                  rsel = RS_LVL;
    end

    assign any_hit = (rsel != RS_NONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            sel_q  <= '0;
            arm_q  <= '0;
        end else if (bus_wr) begin
            if (rsel == RS_MASK) mask_q <= bus_wdata[EW-1:0];
            if (rsel == RS_SEL)  sel_q  <= bus_wdata[EW-1:0];
            if (rsel == RS_ARM)  arm_q  <= bus_wdata[EW-1:0];
        end
    end

    always_comb begin
        rd_mux = '0;
        case (rsel)
            RS_PEND: rd_mux = DW'(pend_i);
            RS_MASK: rd_mux = DW'(mask_q);
            RS_SEL:  rd_mux = DW'(sel_q);
            RS_ARM:  rd_mux = DW'(arm_q);
            RS_CODE: rd_mux = DW'(code_i);
            RS_LVL: begin
                for (int i = 0; i < NL; i++)
                    if (lvl_hit[i]) rd_mux = DW'(lvl_q[i]);
            end
            default: rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            bus_rdata <= '0;
        else if (bus_rd)
            bus_rdata <= rd_mux;
    end

    assign lvl_o        = lvl_q;
    assign mask_o       = mask_q;
    assign sel_o        = sel_q;
    assign arm_o        = arm_q;
    assign pend_wr_o    = bus_wr && (rsel == RS_PEND);
    assign pend_wdata_o = bus_wdata[EW-1:0];

    AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !any_hit) |=> (bus_rdata == '0)); // R10
    AST_UPPER_BITS_ZERO: assert property (@(posedge clk) disable iff (rst)
        bus_rd |=> (bus_rdata[DW-1:CW] == '0)); // R2
endmodule

// File: rtl/thr_cmp.sv
module thr_cmp #(
    parameter int CW = thr_pkg::CODE_W,
    parameter int NL = thr_pkg::NUM_LVL
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  code_valid,
    input  logic [CW-1:0]         code_in,
    input  logic [NL-1:0][CW-1:0] lvl_i,
    output logic [NL-1:0]         up_o,
    output logic [NL-1:0]         dn_o,
    output logic [CW-1:0]         code_q_o
);
    logic [CW-1:0] prev_q;
    logic have_q;
    logic live;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            have_q <= 1'b0;
        end else if (code_valid) begin
            prev_q <= code_in;
            have_q <= 1'b1;
        end
    end

    assign live = code_valid && have_q;

    for (genvar i = 0; i < NL; i++) begin : g_cross
        logic at_or_above_new, at_or_above_old;
        assign at_or_above_new = (code_in >= lvl_i[i]);
        assign at_or_above_old = (prev_q >= lvl_i[i]);
        assign up_o[i] = live && !at_or_above_old && at_or_above_new;
        assign dn_o[i] = live && at_or_above_old && !at_or_above_new;
    end

    assign code_q_o = prev_q;

    AST_CODE_TRACKS_INPUT: assert property (@(posedge clk) disable iff (rst)
        code_valid |=> (code_q_o == $past(code_in))); // R3
    AST_REPEAT_QUIET: assert property (@(posedge clk) disable iff (rst)
        (code_valid && code_in == code_q_o) |-> (up_o == '0 && dn_o == '0)); // R5
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !code_valid |-> (up_o == '0 && dn_o == '0)); // R4
endmodule

// File: rtl/thr_pend.sv
module thr_pend #(
    parameter int NL = thr_pkg::NUM_LVL
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NL-1:0]   up_i,
    input  logic [NL-1:0]   dn_i,
    input  logic [2*NL-1:0] arm_i,
    input  logic [2*NL-1:0] sel_i,
    input  logic [2*NL-1:0] mask_i,
    input  logic            pend_wr_i,
    input  logic [2*NL-1:0] pend_wdata_i,
    output logic [2*NL-1:0] pend_o,
    output logic            irq_o
);
    localparam int EW = 2 * NL;

    logic [EW-1:0] raw_evt, set_vec, keep_vec, pend_q;

    assign raw_evt  = {dn_i, up_i};
    assign set_vec  = raw_evt & arm_i & sel_i;
    assign keep_vec = pend_wr_i ? pend_wdata_i : {EW{1'b1}};

    always_ff @(posedge clk) begin
        if (rst)
            pend_q <= '0;
        else
            pend_q <= (pend_q & keep_vec) | set_vec;
    end

    assign pend_o = pend_q;
    assign irq_o  = |(pend_q & mask_i);

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (set_vec != '0) |=> (($past(set_vec) & ~pend_q) == '0)); // R8
    AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (rst)
        ((pend_q & ~$past(pend_q) & ~$past(raw_evt & arm_i & sel_i)) == '0)); // R6
    AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (rst)
        (pend_wr_i && pend_wdata_i == '0 && set_vec == '0) |=> (pend_q == '0)); // R7
    AST_IRQ_NEEDS_PENDING: assert property (@(posedge clk) disable iff (rst)
        (pend_q == '0) |-> !irq_o); // R9
endmodule

// File: rtl/thermal_trip_irq.sv
module thermal_trip_irq #(
    parameter int CW = thr_pkg::CODE_W,
    parameter int NL = thr_pkg::NUM_LVL,
    parameter int AW = thr_pkg::ADDR_W,
    parameter int DW = thr_pkg::DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_wr,
    input  logic [DW-1:0] bus_wdata,
    input  logic          bus_rd,
    output logic [DW-1:0] bus_rdata,
    input  logic [CW-1:0] code_in,
    input  logic          code_valid,
    output logic          irq_out
);
    localparam int EW = 2 * NL;

    logic [NL-1:0][CW-1:0] lvl;
    logic [EW-1:0] mask, sel, arm, pend, pend_wdata;
    logic pend_wr;
    logic [NL-1:0] up, dn;
    logic [CW-1:0] code_q;

    thr_regs #(.CW(CW), .NL(NL), .AW(AW), .DW(DW)) u_regs (
        .clk(clk), .rst(rst),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .pend_i(pend), .code_i(code_q),
        .lvl_o(lvl), .mask_o(mask), .sel_o(sel), .arm_o(arm),
        .pend_wr_o(pend_wr), .pend_wdata_o(pend_wdata)
    );

    thr_cmp #(.CW(CW), .NL(NL)) u_cmp (
        .clk(clk), .rst(rst),
        .code_valid(code_valid), .code_in(code_in), .lvl_i(lvl),
        .up_o(up), .dn_o(dn), .code_q_o(code_q)
    );

    thr_pend #(.NL(NL)) u_pend (
        .clk(clk), .rst(rst),
        .up_i(up), .dn_i(dn), .arm_i(arm), .sel_i(sel), .mask_i(mask),
        .pend_wr_i(pend_wr), .pend_wdata_i(pend_wdata),
        .pend_o(pend), .irq_o(irq_out)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> (!irq_out && bus_rdata == '0)); // R1
endmodule

// File: tb/sim_thermal_trip_irq.sv
module sim_thermal_trip_irq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic [11:0] code_in = '0;
    logic        code_valid = 1'b0;
    logic        irq_out;

    int n_checks = 0;
    int n_fail = 0;
    logic [31:0] exp_q[$];
    string tag_q[$];
    logic fire;
    bit done = 1'b0;

    always #5 clk = ~clk;

    thermal_trip_irq u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .code_in(code_in), .code_valid(code_valid), .irq_out(irq_out)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic send(input logic [11:0] c);
        @(negedge clk);
        code_in = c; code_valid = 1'b1;
        @(negedge clk);
        code_valid = 1'b0;
    endtask

    task automatic send_and_clear(input logic [11:0] c, input logic [31:0] d);
        @(negedge clk);
        code_in = c; code_valid = 1'b1;
        bus_addr = 8'h04; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        code_valid = 1'b0; bus_wr = 1'b0;
    endtask

    // Scoreboard monitor: pops an expected read value for every read strobe.
    initial begin
        forever begin
            @(posedge clk);
            fire = bus_rd;
            @(negedge clk);
            if (fire) begin
                if (exp_q.size() == 0) begin
                    check("monitor: unexpected read", 32'h1, 32'h0);
                end else begin
                    logic [31:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(t, bus_rdata, e);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        check("R1 irq after reset", 32'(irq_out), 32'h0);
        rd(8'h04, 32'h0, "R1 pending reset");
        rd(8'h08, 32'h0, "R1 mask reset");
        rd(8'h0C, 32'h0, "R1 select reset");
        rd(8'h10, 32'h0, "R1 arm reset");
        rd(8'h14, 32'h0, "R1 level1 reset");
        rd(8'h28, 32'h0, "R1 code reset");

        wr(8'h14, 32'h0000_0100);
        wr(8'h18, 32'h0000_0800);
        wr(8'h1C, 32'hFFFF_FC00);
        wr(8'h0C, 32'h0000_00FF);
        rd(8'h1C, 32'h0000_0C00, "R2 level3 upper bits dropped");
        rd(8'h0C, 32'h0000_003F, "R2 select 6 bits");
        rd(8'h14, 32'h0000_0100, "R2 level1 readback");
        rd(8'h18, 32'h0000_0800, "R2 level2 readback");
        wr(8'h10, 32'h0000_003F);

        send(12'h900);
        rd(8'h04, 32'h0, "R5 first sample quiet");
        rd(8'h28, 32'h0000_0900, "R3 latest code");
        send(12'h900);
        rd(8'h04, 32'h0, "R5 repeated code quiet");

        send(12'h0F0);
        rd(8'h04, 32'h0000_0018, "R4 falling levels 1 and 2");
        check("R9 masked event keeps irq low", 32'(irq_out), 32'h0);
        wr(8'h08, 32'h0000_0008);
        check("R9 unmask pending raises irq", 32'(irq_out), 32'h1);

        wr(8'h04, 32'h0000_0010);
        rd(8'h04, 32'h0000_0010, "R7 per-bit clear");
        check("R9 irq drops after clear", 32'(irq_out), 32'h0);
        wr(8'h04, 32'h0);
        rd(8'h04, 32'h0, "R7 write zero clears all");

        send(12'hC00);
        rd(8'h04, 32'h0000_0007, "R4 rising incl equal level3");

        wr(8'h04, 32'h0);
        wr(8'h0C, 32'h0000_003E);
        send(12'h050);
        send(12'h100);
        rd(8'h04, 32'h0000_0038, "R6 unselected rising ignored");
        wr(8'h0C, 32'h0000_003F);
        wr(8'h10, 32'h0000_003D);
        send(12'h050);
        send(12'h900);
        rd(8'h04, 32'h0000_0039, "R6 disarmed level2 rising ignored");

        send_and_clear(12'h050, 32'h0);
        rd(8'h04, 32'h0000_0018, "R8 set wins over clear");
        check("R9 irq with mask bit3", 32'(irq_out), 32'h1);
        wr(8'h08, 32'h0);
        check("R9 irq masked off", 32'(irq_out), 32'h0);

        wr(8'h24, 32'hFFFF_FFFF);
        wr(8'h28, 32'h0000_0123);
        rd(8'h24, 32'h0, "R10 unmapped reads zero");
        rd(8'h00, 32'h0, "R10 address zero reads zero");
        rd(8'h28, 32'h0000_0050, "R3 code write ignored");
        rd(8'h10, 32'h0000_003D, "R10 arm untouched");
        rd(8'h14, 32'h0000_0100, "R10 level1 untouched");

        wr(8'h04, 32'h0);
        send(12'h100);
        rd(8'h04, 32'h0000_0001, "R4 rising to equal level1");
        wr(8'h04, 32'h0);
        send(12'h0FF);
        rd(8'h04, 32'h0000_0008, "R4 falling from equal level1");

        repeat (3) @(negedge clk);
        check("scoreboard drained", 32'(exp_q.size()), 32'h0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule